// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit control and status register that remembers why the device last left reset and carries two control enables. Hardware event pulses mark flags: brown-out, external master clear, a reset instruction, a watchdog time-out, a watchdog-clear instruction and a sleep instruction. Power-on reset arrives on an asynchronous active-low input and puts the whole register into its initial state. Software reads the register at all times through `rd_data` and writes it through a one-cycle write strobe. Address decode happens outside the block.

Two bits are control enables. The interrupt-priority enable is driven out as a level that selects two-level interrupt priority when it is 1 and single-level compatibility mode when it is 0. Any reset event clears it. The long-write enable is cleared only by power-on or master clear. It is combined with the programming-voltage indication and the target of a table write to give a permission for writes to internal program memory. This permission never applies to writes to external program memory.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_n` is low, `rd_data` reads 0x1C at once, without waiting for a clock. This value is every layout bit at its initial state. Bit 5 always reads 0, and a write of 1 to bit 5 is ignored.
- R2: A write with `sw_we` high and no hardware event present loads `sw_wdata` with bit 5 forced to 0. The new value appears on `rd_data` after the next rising clock edge.
- R3: Bit 6 (long-write enable) is cleared by `mclr_evt` or by power-on. `bor_evt`, `rinst_evt` and `wdt_to_evt` leave it unchanged.
- R4: Bit 7 (interrupt-priority enable) is cleared by any of `bor_evt`, `mclr_evt`, `rinst_evt` or `wdt_to_evt`. `prio_en` follows bit 7: 1 means two priority levels, 0 means single-level mode.
- R5: Bit 4 (reset-instruction flag) goes to 0 one edge after `rinst_evt`. It returns to 1 only through a software write or power-on.
- R6: Bit 3 (time-out flag) goes to 1 after `wdt_clr_evt` or `sleep_evt` and to 0 after `wdt_to_evt`. When a set and a clear arrive in the same cycle, the clear wins.
- R7: Bit 2 (power-down flag) goes to 1 after `wdt_clr_evt` and to 0 after `sleep_evt`. Sleep wins when both pulse in the same cycle.
- R8: Power-on clears bit 1 (power-on flag) and bit 0 (brown-out flag). `bor_evt` clears bit 0 and leaves bit 1 alone.
- R9: When a hardware event and a software write target the same bit in one cycle, the hardware event decides the new value of that bit.
- R10: `int_wr_en` is 1 exactly when bit 6, `hv_prog` and `tbl_wr_req` are all 1 and `tbl_wr_ext` is 0. It is combinational, with no clock delay.
- R11: In a cycle with no event pulse and no write, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| bor_evt | input | 1 | Brown-out reset event pulse |
| mclr_evt | input | 1 | External master-clear reset event pulse |
| rinst_evt | input | 1 | Reset instruction event pulse |
| wdt_to_evt | input | 1 | Watchdog time-out event pulse |
| wdt_clr_evt | input | 1 | Watchdog-clear instruction pulse |
| sleep_evt | input | 1 | Sleep instruction pulse |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| hv_prog | input | 1 | Programming voltage present on the reset pin |
| tbl_wr_req | input | 1 | Table write request |
| tbl_wr_ext | input | 1 | Table write targets external program memory |
| rd_data | output | 8 | Register read value |
| prio_en | output | 1 | Interrupt priority levels enabled |
| int_wr_en | output | 1 | Internal program memory write permitted |

## Verification
The hardest cases to reach are those where several sources collide on one bit in a single cycle. Examples are a time-out with a sleep pulse, a watchdog clear with a sleep pulse, and a brown-out or reset instruction with a software write that tries to set the same flag. Random stimulus makes such overlaps only rarely, so directed steps force each pairing first. A seeded random phase then pulses every event at a high rate beside frequent writes and occasional mid-run power-on resets, so many overlaps occur. Each cycle the read value is compared with a bench model built from the priority rules.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int RCR_W = 8;

  localparam int B_PRIO = 7;
  localparam int B_LWR  = 6;
  localparam int B_GAP  = 5;
  localparam int B_RI   = 4;
  localparam int B_TO   = 3;
  localparam int B_PD   = 2;
  localparam int B_POR  = 1;
  localparam int B_BOR  = 0;

  localparam logic [RCR_W-1:0] RCR_RST_VAL = 8'h1C;
  localparam logic [RCR_W-1:0] RCR_WR_MASK = ~(RCR_W'(1) << B_GAP);

  typedef struct packed {
    logic bor;
    logic mclr;
    logic rinst;
    logic wdt_to;
    logic wdt_clr;
    logic sleep;
  } rcr_evt_t;
endpackage

// File: rtl/rcr_rst_sync.sv
module rcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcr_evt_decode.sv
module rcr_evt_decode
  import rcr_pkg::*;
(
  input  rcr_evt_t         ev,
  output logic [RCR_W-1:0] hw_set,
  output logic [RCR_W-1:0] hw_clr
);
  logic any_reset;

  always_comb begin
    any_reset = ev.bor | ev.mclr | ev.rinst | ev.wdt_to;
    hw_set = '0;
    hw_clr = '0;
    // priority enable drops on every non-power-on reset
    hw_clr[B_PRIO] = any_reset;
    // long-write enable survives all resets but master clear
    hw_clr[B_LWR]  = ev.mclr;
    hw_clr[B_RI]   = ev.rinst;
    hw_set[B_TO]   = ev.wdt_clr | ev.sleep;
    hw_clr[B_TO]   = ev.wdt_to;
    hw_set[B_PD]   = ev.wdt_clr;
    hw_clr[B_PD]   = ev.sleep;
    hw_clr[B_BOR]  = ev.bor;
  end
endmodule

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_d,
  output logic q
);
  logic ce;
  logic d;

  // clear over set over software write
  always_comb begin
    ce = hw_clr | hw_set | sw_we;
    if (hw_clr)      d = 1'b0;
    else if (hw_set) d = 1'b1;
    else             d = sw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/rcr_wr_gate.sv
module rcr_wr_gate (
  input  logic lwr_bit,
  input  logic hv_prog,
  input  logic tbl_wr_req,
  input  logic tbl_wr_ext,
  output logic allow
);
  always_comb begin
    allow = lwr_bit & hv_prog & tbl_wr_req & ~tbl_wr_ext;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             bor_evt,
  input  logic             mclr_evt,
  input  logic             rinst_evt,
  input  logic             wdt_to_evt,
  input  logic             wdt_clr_evt,
  input  logic             sleep_evt,
  input  logic             sw_we,
  input  logic [RCR_W-1:0] sw_wdata,
  input  logic             hv_prog,
  input  logic             tbl_wr_req,
  input  logic             tbl_wr_ext,
  output logic [RCR_W-1:0] rd_data,
  output logic             prio_en,
  output logic             int_wr_en
);
  logic             rst_q_n;
  rcr_evt_t         ev;
  logic [RCR_W-1:0] hw_set;
  logic [RCR_W-1:0] hw_clr;
  logic [RCR_W-1:0] bit_we;
  logic [RCR_W-1:0] q;

  rcr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_q_n)
  );

  always_comb begin
    ev.bor     = bor_evt;
    ev.mclr    = mclr_evt;
    ev.rinst   = rinst_evt;
    ev.wdt_to  = wdt_to_evt;
    ev.wdt_clr = wdt_clr_evt;
    ev.sleep   = sleep_evt;
    bit_we     = {RCR_W{sw_we}} & RCR_WR_MASK;
  end

  rcr_evt_decode u_dec (
    .ev     (ev),
    .hw_set (hw_set),
    .hw_clr (hw_clr)
  );

  for (genvar i = 0; i < RCR_W; i++) begin : g_bit
    rcr_flag_cell #(.RST_VAL(RCR_RST_VAL[i])) u_cell (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .hw_set (hw_set[i]),
      .hw_clr (hw_clr[i]),
      .sw_we  (bit_we[i]),
      .sw_d   (sw_wdata[i]),
      .q      (q[i])
    );
  end

  rcr_wr_gate u_gate (
    .lwr_bit    (q[B_LWR]),
    .hv_prog    (hv_prog),
    .tbl_wr_req (tbl_wr_req),
    .tbl_wr_ext (tbl_wr_ext),
    .allow      (int_wr_en)
  );

  assign rd_data = q;
  assign prio_en = q[B_PRIO];
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bor_evt,
  input logic       mclr_evt,
  input logic       rinst_evt,
  input logic       wdt_to_evt,
  input logic       wdt_clr_evt,
  input logic       sleep_evt,
  input logic       sw_we,
  input logic [7:0] sw_wdata,
  input logic       hv_prog,
  input logic       tbl_wr_req,
  input logic       tbl_wr_ext,
  input logic [7:0] rd_data,
  input logic       int_wr_en
);
  logic any_evt;
  assign any_evt = bor_evt | mclr_evt | rinst_evt | wdt_to_evt | wdt_clr_evt | sleep_evt;

  assert_gap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] == 1'b0);

  assert_sw_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !any_evt) |=> rd_data == ($past(sw_wdata) & 8'hDF));

  assert_lwr_mclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_evt |=> !rd_data[6]);

  assert_lwr_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr_evt && !sw_we) |=> rd_data[6] == $past(rd_data[6]));

  assert_prio_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_evt || mclr_evt || rinst_evt || wdt_to_evt) |=> !rd_data[7]);

  assert_ri_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rinst_evt |=> !rd_data[4]);

  assert_ri_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[4]) |-> $past(sw_we && sw_wdata[4]));

  assert_to_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to_evt |=> !rd_data[3]);

  assert_to_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_clr_evt || sleep_evt) && !wdt_to_evt) |=> rd_data[3]);

  assert_pd_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt |=> !rd_data[2]);

  assert_pd_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr_evt && !sleep_evt) |=> rd_data[2]);

  assert_bor_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bor_evt |=> !rd_data[0]);

  assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rinst_evt && sw_we && sw_wdata[4]) |=> !rd_data[4]);

  assert_ext_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr_ext || !hv_prog || !tbl_wr_req || !rd_data[6]) |-> !int_wr_en);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && !sw_we) |=> $stable(rd_data));
endmodule

bind rst_cause_reg rcr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .bor_evt     (bor_evt),
  .mclr_evt    (mclr_evt),
  .rinst_evt   (rinst_evt),
  .wdt_to_evt  (wdt_to_evt),
  .wdt_clr_evt (wdt_clr_evt),
  .sleep_evt   (sleep_evt),
  .sw_we       (sw_we),
  .sw_wdata    (sw_wdata),
  .hv_prog     (hv_prog),
  .tbl_wr_req  (tbl_wr_req),
  .tbl_wr_ext  (tbl_wr_ext),
  .rd_data     (rd_data),
  .int_wr_en   (int_wr_en)
);

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic       clk = 1'b0;
  logic       por_n;
  logic       bor_evt, mclr_evt, rinst_evt, wdt_to_evt, wdt_clr_evt, sleep_evt;
  logic       sw_we;
  logic [7:0] sw_wdata;
  logic       hv_prog, tbl_wr_req, tbl_wr_ext;
  logic [7:0] rd_data;
  logic       prio_en, int_wr_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] mdl_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u0 (
    .clk(clk), .por_n(por_n), .bor_evt(bor_evt), .mclr_evt(mclr_evt),
    .rinst_evt(rinst_evt), .wdt_to_evt(wdt_to_evt), .wdt_clr_evt(wdt_clr_evt),
    .sleep_evt(sleep_evt), .sw_we(sw_we), .sw_wdata(sw_wdata), .hv_prog(hv_prog),
    .tbl_wr_req(tbl_wr_req), .tbl_wr_ext(tbl_wr_ext), .rd_data(rd_data),
    .prio_en(prio_en), .int_wr_en(int_wr_en)
  );

  // expected next value from the requirement rules
  function automatic logic [7:0] nxt(input logic [7:0] q, input logic b, mc, ri,
                                     wt, wc, sl, we, input logic [7:0] wd);
    logic [7:0] r;
    r = q;
    if (we) r = wd & 8'hDF;
    if (wc | sl) r[3] = 1'b1;
    if (wt) r[3] = 1'b0;
    if (wc) r[2] = 1'b1;
    if (sl) r[2] = 1'b0;
    if (b | mc | ri | wt) r[7] = 1'b0;
    if (mc) r[6] = 1'b0;
    if (ri) r[4] = 1'b0;
    if (b) r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic gate_exp(input logic [7:0] q, input logic hv, rq, ex);
    return q[6] & hv & rq & ~ex;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {bor_evt, mclr_evt, rinst_evt, wdt_to_evt, wdt_clr_evt, sleep_evt} = '0;
    sw_we = 1'b0;
    sw_wdata = '0;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic b, mc, ri, wt, wc, sl, we, input logic [7:0] wd,
                      input string tag);
    bor_evt = b; mclr_evt = mc; rinst_evt = ri; wdt_to_evt = wt;
    wdt_clr_evt = wc; sleep_evt = sl; sw_we = we; sw_wdata = wd;
    mdl_q = nxt(mdl_q, b, mc, ri, wt, wc, sl, we, wd);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(tag, rd_data, mdl_q);
  endtask

  task automatic do_por();
    por_n = 1'b0;
    #1;
    chk("R1 async power-on value", rd_data, 8'h1C);
    chk("R8 power-on clears flags", {6'b0, rd_data[1:0]}, 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    mdl_q = 8'h1C;
    chk("R1 value after release", rd_data, 8'h1C);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYCLES && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    por_n = 1'b0;
    hv_prog = 1'b0; tbl_wr_req = 1'b0; tbl_wr_ext = 1'b0;
    idle_inputs();
    mdl_q = 8'h1C;
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, 8'h1C);
    chk("R4 prio_en after reset", {7'b0, prio_en}, 8'h00);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 value after release", rd_data, 8'h1C);

    step(0,0,0,0,0,0,1,8'hFF, "R1 R2 write all ones, bit5 ignored");
    chk("R4 prio_en set", {7'b0, prio_en}, 8'h01);
    step(1,0,0,0,0,0,0,8'h00, "R3 R4 R8 brown-out");
    step(0,0,1,0,0,0,0,8'h00, "R5 reset instruction");
    step(0,0,0,1,0,0,0,8'h00, "R6 time-out");
    step(0,0,0,0,0,1,0,8'h00, "R6 R7 sleep");
    step(0,0,0,0,1,0,0,8'h00, "R7 watchdog clear");
    step(0,0,0,1,0,1,0,8'h00, "R6 time-out beats sleep");
    step(0,0,0,0,1,1,0,8'h00, "R7 sleep beats watchdog clear");
    step(1,0,0,0,0,0,1,8'hFF, "R9 brown-out beats write");
    step(0,0,1,0,0,0,1,8'hFF, "R9 R5 reset instruction beats write");
    step(0,0,0,0,0,0,0,8'h00, "R11 idle hold");
    step(0,0,0,0,0,0,1,8'h10, "R5 software restores flag");
    step(0,0,0,0,0,0,1,8'hFF, "R2 write all ones");
    step(0,1,0,0,0,0,0,8'h00, "R3 master clear drops long-write");
    chk("R4 prio_en cleared", {7'b0, prio_en}, 8'h00);

    step(0,0,0,0,0,0,1,8'h40, "R2 set long-write");
    hv_prog = 1; tbl_wr_req = 1; tbl_wr_ext = 0; #1;
    chk("R10 internal write permitted", {7'b0, int_wr_en}, 8'h01);
    tbl_wr_ext = 1; #1;
    chk("R10 external write not gated", {7'b0, int_wr_en}, 8'h00);
    tbl_wr_ext = 0; hv_prog = 0; #1;
    chk("R10 no programming voltage", {7'b0, int_wr_en}, 8'h00);
    @(negedge clk);

    step(0,0,0,0,0,0,1,8'hFF, "R2 write before power-on");
    do_por();

    for (int n = 0; n < 1500; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if (($urandom % 150) == 0) begin
        do_por();
      end else begin
        hv_prog = r[0]; tbl_wr_req = r[1]; tbl_wr_ext = r[2];
        #1;
        chk("R10 random gate", {7'b0, int_wr_en},
            {7'b0, gate_exp(mdl_q, hv_prog, tbl_wr_req, tbl_wr_ext)});
        chk("R4 random prio_en", {7'b0, prio_en}, {7'b0, mdl_q[7]});
        step(($urandom % 9) == 0, ($urandom % 12) == 0, ($urandom % 9) == 0,
             ($urandom % 7) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
             ($urandom % 3) == 0, 8'($urandom), "R2 R9 R11 random step");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule